// File: doc/BRIEF.md
# Level-Interrupt EOI Scanner with Storm Throttle

This block takes end-of-interrupt broadcasts and applies them to a table of interrupt pins. Each broadcast carries a vector, a trigger mode and the number of the target that sent it. The block walks the pin table one index per cycle and compares each pin's vector with the broadcast vector. A matching pin always receives an acknowledge strobe. For a level-mode broadcast that is not flagged as directed, the block also clears the pin's remote-IRR. If the pin is still pending and unmasked, the block then requests redelivery.

A guest that never services a level-triggered source can turn this loop into an interrupt storm. To prevent that, each pin keeps a count of back-to-back redeliveries. When the count reaches a configurable limit, the count returns to zero and the redelivery is not issued. Instead a deferral timer starts. When it expires, the block issues one redelivery sweep over every pin that is level-triggered, pending, unmasked and has remote-IRR clear.

A small tracker also follows one coalescing source. Each target has a tracking bit and a recorded vector, and the tracker keeps a count of targets that still owe an EOI. The delivery logic outside the block loads the tracking entries. The pin table and the delivery of interrupts are both held outside this block.

Top module: `eoi_storm_throttle`

## Requirements
- R1: A pin whose vector differs from the broadcast vector gets no acknowledge, no remote-IRR clear and no redelivery strobe during that scan.
- R2: When the broadcast trigger mode is edge (`eoi_level`=0) or `directed_eoi`=1, a matching pin gets only an acknowledge strobe. There is no remote-IRR clear and no redelivery.
- R3: For a level broadcast that is not directed, every matching pin gets a `rirr_clr` strobe. A matching pin that is masked or not pending gets no redelivery.
- R4: A matching pin that is unmasked and pending gets an immediate `redeliver` strobe in the same scan, as long as its incremented successive count stays below STORM_LIMIT.
- R5: When the incremented count equals STORM_LIMIT, the count returns to 0 and no immediate redelivery is issued. DEFER_CYCLES later, `redeliver` pulses once for every pin with `pin_level`=1, pending, unmasked and `pin_rirr`=0.
- R6: A matching pin that is masked or not pending, under a level broadcast that is not directed, has its successive count reset to 0.
- R7: `trk_load` sets a target's tracking bit, records its vector and increments `trk_outstanding`, unless the bit is already set. An accepted EOI from a target whose bit is set and whose recorded vector equals the EOI vector clears the bit and decrements the count. Any other EOI leaves the count unchanged.
- R8: Reset clears all successive counts, the tracker, the outputs and any deferral that is in progress, so that no deferred redelivery follows a reset.
- R9: An EOI is accepted only while `busy`=0. After acceptance, `busy` stays high for exactly NPINS cycles, and pins are visited in ascending index order, one per cycle. An EOI presented while `busy`=1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoi_valid | input | 1 | EOI broadcast present |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_level | input | 1 | 1 = level trigger mode, 0 = edge |
| eoi_src | input | log2(NTARGETS) | Target that issued the EOI |
| directed_eoi | input | 1 | Directed-EOI enable; suppresses remote-IRR clearing |
| pin_vector | input | NPINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| pin_level | input | NPINS | Per-pin trigger mode, 1 = level |
| pin_mask | input | NPINS | Per-pin mask |
| pin_pending | input | NPINS | Per-pin pending (IRR) state |
| pin_rirr | input | NPINS | Per-pin remote-IRR state |
| trk_load | input | 1 | Record a tracked delivery |
| trk_target | input | log2(NTARGETS) | Target of the tracked delivery |
| trk_vector | input | VEC_W | Vector of the tracked delivery |
| busy | output | 1 | Scan in progress |
| ack_notify | output | NPINS | One-cycle acknowledge strobe per pin |
| rirr_clr | output | NPINS | One-cycle remote-IRR clear strobe per pin |
| redeliver | output | NPINS | One-cycle redelivery request per pin |
| trk_outstanding | output | log2(NTARGETS+1) | Count of tracked targets still owing an EOI |

## Verification
The bench drives a pin through the full storm run. A design that defers one EOI too early or too late shows up as a missing or extra immediate redelivery on the limit-th broadcast. A design that forgets to re-arm after the deferral would let the next run of redeliveries go wrong. Two further cases reset the count in mid-run, once by masking the pin and once by a reset. A design that misses either reset defers too soon. A pulse of reset while the deferral timer is running must produce no late redelivery. At timer expiry, pins with remote-IRR still set and edge-mode pins must stay quiet. Other cases cover a shared vector across two pins, EOIs dropped while busy, and tracker EOIs with a mismatched vector or a repeated EOI, which must not decrement the outstanding count.

// File: rtl/eoi_thr_pkg.sv
package eoi_thr_pkg;

  // Decision taken for the pin visited in the current scan cycle.
  typedef struct packed {
    logic match;   // vector equal to the broadcast vector
    logic clear;   // remote-IRR clear applies
    logic count;   // pin unmasked and pending: redelivery wanted
    logic limit;   // successive count reached the storm limit
  } eoi_act_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/eoi_scan_seq.sv
module eoi_scan_seq import eoi_thr_pkg::*; #(
  parameter int NPINS = 24,
  localparam int IW = idx_w(NPINS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(NPINS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy && start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eoi_storm_ctr.sv
module eoi_storm_ctr import eoi_thr_pkg::*; #(
  parameter int NPINS = 24,
  parameter int STORM_LIMIT = 10000,
  localparam int IW = idx_w(NPINS),
  localparam int CW = $clog2(STORM_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] idx,
  output logic [CW-1:0] rd_cnt,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val
);
  logic [CW-1:0] cnt_mem [NPINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPINS; i++) cnt_mem[i] <= '0;
    end else if (wr_en) begin
      cnt_mem[idx] <= wr_val;
    end
  end

  assign rd_cnt = cnt_mem[idx];
endmodule

// File: rtl/eoi_defer_timer.sv
module eoi_defer_timer #(
  parameter int DEFER_CYCLES = 1000000,
  localparam int DW = $clog2(DEFER_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic fire
);
  logic          running;
  logic [DW-1:0] remain;

  assign fire = running && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      remain  <= '0;
    end else if (arm && (!running || fire)) begin
      running <= 1'b1;
      remain  <= DW'(DEFER_CYCLES - 1);
    end else if (fire) begin
      running <= 1'b0;
    end else if (running) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/eoi_coal_track.sv
module eoi_coal_track #(
  parameter int NTARGETS = 16,
  parameter int VEC_W = 8,
  localparam int TW = $clog2(NTARGETS),
  localparam int OW = $clog2(NTARGETS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TW-1:0]    load_tgt,
  input  logic [VEC_W-1:0] load_vec,
  input  logic             eoi,
  input  logic [TW-1:0]    eoi_src,
  input  logic [VEC_W-1:0] eoi_vec,
  output logic [OW-1:0]    outstanding
);
  logic [NTARGETS-1:0] owe;
  logic [VEC_W-1:0]    rec_vec [NTARGETS];
  logic                do_set, do_clr;

  assign do_clr = eoi && owe[eoi_src] && (rec_vec[eoi_src] == eoi_vec);
  assign do_set = load && !owe[load_tgt];

  always_ff @(posedge clk) begin
    if (rst) begin
      owe         <= '0;
      outstanding <= '0;
      for (int i = 0; i < NTARGETS; i++) rec_vec[i] <= '0;
    end else begin
      if (do_clr) owe[eoi_src] <= 1'b0;
      if (do_set) begin
        owe[load_tgt]     <= 1'b1;
        rec_vec[load_tgt] <= load_vec;
      end
      if (do_set && !do_clr)      outstanding <= outstanding + 1'b1;
      else if (do_clr && !do_set) outstanding <= outstanding - 1'b1;
    end
  end
endmodule

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle import eoi_thr_pkg::*; #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int DEFER_CYCLES = 1000000,
  parameter int NTARGETS = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         eoi_valid,
  input  logic [VEC_W-1:0]             eoi_vector,
  input  logic                         eoi_level,
  input  logic [$clog2(NTARGETS)-1:0]  eoi_src,
  input  logic                         directed_eoi,
  input  logic [NPINS*VEC_W-1:0]       pin_vector,
  input  logic [NPINS-1:0]             pin_level,
  input  logic [NPINS-1:0]             pin_mask,
  input  logic [NPINS-1:0]             pin_pending,
  input  logic [NPINS-1:0]             pin_rirr,
  input  logic                         trk_load,
  input  logic [$clog2(NTARGETS)-1:0]  trk_target,
  input  logic [VEC_W-1:0]             trk_vector,
  output logic                         busy,
  output logic [NPINS-1:0]             ack_notify,
  output logic [NPINS-1:0]             rirr_clr,
  output logic [NPINS-1:0]             redeliver,
  output logic [$clog2(NTARGETS+1)-1:0] trk_outstanding
);
  localparam int IW = idx_w(NPINS);
  localparam int CW = $clog2(STORM_LIMIT + 1);

  logic [VEC_W-1:0] vec_arr [NPINS];
  for (genvar g = 0; g < NPINS; g++) begin : g_vec
    assign vec_arr[g] = pin_vector[g*VEC_W +: VEC_W];
  end

  logic             accept;
  logic [VEC_W-1:0] e_vec;
  logic             e_noclr;
  logic [IW-1:0]    scan_idx;
  logic [CW-1:0]    cnt_cur, cnt_inc, cnt_nxt;
  logic             cnt_we;
  logic             defer_fire;
  logic [NPINS-1:0] idx_oh, fire_mask;
  eoi_act_t         act;

  assign accept = eoi_valid && !busy;

  // Broadcast fields held for the length of the scan.
  always_ff @(posedge clk) begin
    if (rst) begin
      e_vec   <= '0;
      e_noclr <= 1'b0;
    end else if (accept) begin
      e_vec   <= eoi_vector;
      e_noclr <= !eoi_level || directed_eoi;
    end
  end

  eoi_scan_seq #(.NPINS(NPINS)) scan_i (
    .clk(clk), .rst(rst), .start(accept), .busy(busy), .idx(scan_idx)
  );

  eoi_storm_ctr #(.NPINS(NPINS), .STORM_LIMIT(STORM_LIMIT)) ctr_i (
    .clk(clk), .rst(rst), .idx(scan_idx), .rd_cnt(cnt_cur),
    .wr_en(cnt_we), .wr_val(cnt_nxt)
  );

  assign cnt_inc = cnt_cur + 1'b1;

  always_comb begin
    act.match = busy && (vec_arr[scan_idx] == e_vec);
    act.clear = act.match && !e_noclr;
    act.count = act.clear && !pin_mask[scan_idx] && pin_pending[scan_idx];
    act.limit = act.count && (cnt_inc == CW'(STORM_LIMIT));
    cnt_we    = act.clear;
    if (act.count && !act.limit) cnt_nxt = cnt_inc;
    else                         cnt_nxt = '0;
  end

  eoi_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) tmr_i (
    .clk(clk), .rst(rst), .arm(act.limit), .fire(defer_fire)
  );

  assign idx_oh    = NPINS'(1) << scan_idx;
  assign fire_mask = pin_level & pin_pending & ~pin_mask & ~pin_rirr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_notify <= '0;
      rirr_clr   <= '0;
      redeliver  <= '0;
    end else begin
      ack_notify <= act.match ? idx_oh : '0;
      rirr_clr   <= act.clear ? idx_oh : '0;
      redeliver  <= ((act.count && !act.limit) ? idx_oh : '0)
                  | (defer_fire ? fire_mask : '0);
    end
  end

  eoi_coal_track #(.NTARGETS(NTARGETS), .VEC_W(VEC_W)) trk_i (
    .clk(clk), .rst(rst), .load(trk_load), .load_tgt(trk_target),
    .load_vec(trk_vector), .eoi(accept), .eoi_src(eoi_src),
    .eoi_vec(eoi_vector), .outstanding(trk_outstanding)
  );
endmodule

// File: rtl/eoi_storm_throttle_chk.sv
module eoi_storm_throttle_chk #(
  parameter int NPINS = 24,
  parameter int NTARGETS = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          eoi_valid,
  input logic                          eoi_level,
  input logic                          directed_eoi,
  input logic                          busy,
  input logic [NPINS-1:0]              rirr_clr,
  input logic [NPINS-1:0]              ack_notify,
  input logic [$clog2(NTARGETS+1)-1:0] trk_outstanding
);
  logic noclr_mode;
  int   busy_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      noclr_mode <= 1'b0;
      busy_run   <= 0;
    end else begin
      if (eoi_valid && !busy) noclr_mode <= !eoi_level || directed_eoi;
      busy_run <= busy ? busy_run + 1 : 0;
    end
  end

  a_r9_one_clear_per_cycle: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rirr_clr));
  a_r9_one_ack_per_cycle: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_notify));
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !busy) |=> busy);
  a_r9_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_run <= NPINS);
  a_r3_clear_follows_scan: assert property (@(posedge clk) disable iff (rst)
    (|rirr_clr) |-> $past(busy));
  a_r2_no_clear_edge_or_directed: assert property (@(posedge clk) disable iff (rst)
    (|rirr_clr) |-> !noclr_mode);
  a_r7_outstanding_bounded: assert property (@(posedge clk) disable iff (rst)
    trk_outstanding <= ($clog2(NTARGETS+1))'(NTARGETS));
endmodule

bind eoi_storm_throttle eoi_storm_throttle_chk #(.NPINS(NPINS), .NTARGETS(NTARGETS)) chk_i (
  .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_level(eoi_level),
  .directed_eoi(directed_eoi), .busy(busy), .rirr_clr(rirr_clr),
  .ack_notify(ack_notify), .trk_outstanding(trk_outstanding)
);

// File: tb/eoi_storm_throttle_tb_top.sv
`timescale 1ns/1ps
module eoi_storm_throttle_tb_top;
  localparam int NP = 4, VW = 8, LIM = 4, DLY = 20, NT = 4;

  logic clk = 0, rst = 1;
  logic eoi_valid = 0, eoi_level = 0, directed_eoi = 0, trk_load = 0;
  logic [VW-1:0] eoi_vector = '0, trk_vector = '0;
  logic [1:0] eoi_src = '0, trk_target = '0;
  logic [VW-1:0] pv [NP];
  logic [NP*VW-1:0] pin_vector;
  logic [NP-1:0] pin_level, pin_mask, pin_pending, pin_rirr;
  logic busy;
  logic [NP-1:0] ack_notify, rirr_clr, redeliver;
  logic [2:0] trk_outstanding;

  assign pin_vector = {pv[3], pv[2], pv[1], pv[0]};

  always #5 clk = ~clk;

  eoi_storm_throttle #(.NPINS(NP), .VEC_W(VW), .STORM_LIMIT(LIM),
                       .DEFER_CYCLES(DLY), .NTARGETS(NT)) dut_i (
    .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_level(eoi_level), .eoi_src(eoi_src), .directed_eoi(directed_eoi),
    .pin_vector(pin_vector), .pin_level(pin_level), .pin_mask(pin_mask),
    .pin_pending(pin_pending), .pin_rirr(pin_rirr), .trk_load(trk_load),
    .trk_target(trk_target), .trk_vector(trk_vector), .busy(busy),
    .ack_notify(ack_notify), .rirr_clr(rirr_clr), .redeliver(redeliver),
    .trk_outstanding(trk_outstanding)
  );

  int errors = 0, checks = 0;
  int n_red [NP], n_clr [NP], n_ack [NP];
  int bcyc;

  always @(negedge clk) begin
    for (int i = 0; i < NP; i++) begin
      n_red[i] += int'(redeliver[i]);
      n_clr[i] += int'(rirr_clr[i]);
      n_ack[i] += int'(ack_notify[i]);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_acc();
    for (int i = 0; i < NP; i++) begin n_red[i] = 0; n_clr[i] = 0; n_ack[i] = 0; end
  endtask

  task automatic do_eoi(input logic [7:0] v, input logic lvl, input logic dir, input logic [1:0] src);
    @(posedge clk); #1;
    clear_acc();
    @(negedge clk);
    eoi_vector = v; eoi_level = lvl; directed_eoi = dir; eoi_src = src; eoi_valid = 1;
    @(negedge clk);
    eoi_valid = 0;
    bcyc = 0;
    while (busy) begin bcyc++; @(negedge clk); end
    @(posedge clk); #1;
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_acc(input int n);
    @(posedge clk); #1;
    clear_acc();
    repeat (n) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic load_trk(input logic [1:0] t, input logic [7:0] v);
    @(negedge clk); trk_load = 1; trk_target = t; trk_vector = v;
    @(negedge clk); trk_load = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pv[0] = 8'h30; pv[1] = 8'h31; pv[2] = 8'h32; pv[3] = 8'h33;
    pin_level = 4'b0111; pin_mask = '0; pin_pending = '0; pin_rirr = '0;
    clear_acc();
    repeat (3) @(negedge clk);
    // Reset state (R8)
    chk("R8 reset busy", int'(busy), 0);
    chk("R8 reset strobes", int'({ack_notify, rirr_clr, redeliver}), 0);
    chk("R8 reset outstanding", int'(trk_outstanding), 0);
    rst = 0;

    // R9 scan length, R3 clear without redelivery, R1 non-matching pins quiet
    do_eoi(8'h31, 1, 0, 0);
    chk("R9 busy cycles", bcyc, NP);
    chk("R3 clear on match", n_clr[1], 1);
    chk("R3 no redeliver not pending", n_red[1], 0);
    chk("R1 no ack on mismatch", n_ack[0] + n_ack[2] + n_ack[3], 0);
    chk("R1 no clear on mismatch", n_clr[0] + n_clr[2] + n_clr[3], 0);

    // R2 edge-mode and directed EOIs: acknowledge only
    pin_pending[1] = 1;
    do_eoi(8'h31, 0, 0, 0);
    chk("R2 edge ack", n_ack[1], 1);
    chk("R2 edge no clear", n_clr[1], 0);
    chk("R2 edge no redeliver", n_red[1], 0);
    do_eoi(8'h31, 1, 1, 0);
    chk("R2 directed ack", n_ack[1], 1);
    chk("R2 directed no clear", n_clr[1] + n_red[1], 0);

    // Shared vector across pins 1 and 2
    pv[2] = 8'h31;
    do_eoi(8'h31, 1, 0, 0);
    chk("R3 shared clear pin1", n_clr[1], 1);
    chk("R3 shared clear pin2", n_clr[2], 1);
    chk("R4 shared redeliver pending pin1", n_red[1], 1);
    chk("R3 shared no redeliver pin2", n_red[2], 0);
    pv[2] = 8'h32;
    pin_pending[1] = 0;
    do_eoi(8'h31, 1, 0, 0);  // resets pin1 count

    // Storm on pin 0 (R4, R5)
    pin_pending[0] = 1;
    for (int k = 1; k < LIM; k++) begin
      do_eoi(8'h30, 1, 0, 0);
      chk("R4 immediate redeliver", n_red[0], 1);
    end
    pin_pending[3:1] = 3'b111; pin_rirr[2] = 1;
    do_eoi(8'h30, 1, 0, 0);
    chk("R5 limit clears rirr", n_clr[0], 1);
    chk("R5 limit no immediate redeliver", n_red[0], 0);
    wait_acc(5);
    chk("R5 not before delay", n_red[0] + n_red[1], 0);
    wait_acc(DLY + 10);
    chk("R5 deferred pin0", n_red[0], 1);
    chk("R5 deferred other level pin", n_red[1], 1);
    chk("R5 deferred skips rirr set", n_red[2], 0);
    chk("R5 deferred skips edge pin", n_red[3], 0);
    pin_pending[3:1] = '0; pin_rirr[2] = 0;

    // R6 masked match resets the count
    do_eoi(8'h30, 1, 0, 0);
    chk("R5 count restarted 1", n_red[0], 1);
    do_eoi(8'h30, 1, 0, 0);
    chk("R5 count restarted 2", n_red[0], 1);
    pin_mask[0] = 1;
    do_eoi(8'h30, 1, 0, 0);
    chk("R3 masked clear", n_clr[0], 1);
    chk("R3 masked no redeliver", n_red[0], 0);
    pin_mask[0] = 0;
    for (int k = 1; k < LIM; k++) begin
      do_eoi(8'h30, 1, 0, 0);
      chk("R6 immediate after mask reset", n_red[0], 1);
    end
    do_eoi(8'h30, 1, 0, 0);
    chk("R6 defers at limit after reset", n_red[0], 0);
    wait_acc(DLY + 10);
    chk("R5 second deferral", n_red[0], 1);

    // R7 coalescing tracker
    load_trk(2'd1, 8'h40);
    chk("R7 load one", int'(trk_outstanding), 1);
    load_trk(2'd2, 8'h41);
    chk("R7 load two", int'(trk_outstanding), 2);
    do_eoi(8'h41, 1, 0, 2'd1);
    chk("R7 vector mismatch keeps", int'(trk_outstanding), 2);
    do_eoi(8'h40, 1, 0, 2'd1);
    chk("R7 match decrements", int'(trk_outstanding), 1);
    do_eoi(8'h40, 1, 0, 2'd1);
    chk("R7 repeat no decrement", int'(trk_outstanding), 1);
    load_trk(2'd1, 8'h40);
    load_trk(2'd1, 8'h40);
    chk("R7 reload set bit ignored", int'(trk_outstanding), 2);

    // R8 reset clears counts and cancels deferral
    do_eoi(8'h30, 1, 0, 0);
    do_eoi(8'h30, 1, 0, 0);
    pulse_rst();
    chk("R8 outstanding cleared", int'(trk_outstanding), 0);
    for (int k = 1; k < LIM; k++) begin
      do_eoi(8'h30, 1, 0, 0);
      chk("R8 count cleared immediate", n_red[0], 1);
    end
    do_eoi(8'h30, 1, 0, 0);
    chk("R8 limit after reset defers", n_red[0], 0);
    pulse_rst();
    wait_acc(DLY + 10);
    chk("R8 deferral cancelled", n_red[0], 0);

    // R9 EOI held during busy is dropped
    @(posedge clk); #1;
    clear_acc();
    @(negedge clk);
    eoi_vector = 8'h30; eoi_level = 1; directed_eoi = 0; eoi_valid = 1;
    repeat (3) @(negedge clk);
    eoi_valid = 0;
    repeat (NP + 3) @(negedge clk);
    @(posedge clk); #1;
    chk("R9 dropped while busy clear", n_clr[0], 1);
    chk("R9 dropped while busy redeliver", n_red[0], 1);
    chk("R9 idle after scan", int'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule